// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns one dedicated interrupt pin and eighteen general-purpose pins into interrupt requests for a small processor. Every raw pin is asynchronous. It passes through a two-flop synchronizer, and a further register holds the previous sample. All edges are found by comparing two successive samples and never by looking at the raw wire.

The dedicated pin has a 2-bit sense mode. It can request on a low level, on any change, on a falling edge or on a rising edge. The eighteen general pins react to changes only. They are split into three groups of unequal size. Each group has its own enable bit, and each pin has its own mask bit.

Edge events set sticky flags, which the processor clears with one-cycle acknowledge pulses. A request leaves the block only while the global interrupt enable is high and the matching enable bit is set. Software reaches the enables, the sense mode and the three per-pin masks through a small register port with combinational read-back.

Top module: `pin_irq_ctrl`

## Requirements
- R1: With sense code 00 (low level), `ext_req` is high exactly while the synchronized dedicated pin is low, subject to the enables in R6. It falls as soon as the sampled pin returns high, with no acknowledge, because no flag is latched in this mode.
- R2: With sense code 01, every change of the sampled dedicated pin sets the external flag. Both a high-to-low and a low-to-high change do so.
- R3: With sense code 10, a high-to-low change of the sampled dedicated pin sets the external flag. A low-to-high change does not set it.
- R4: With sense code 11, a low-to-high change of the sampled dedicated pin sets the external flag. A high-to-low change does not set it.
- R5: Each pin passes through two synchronizer flops and one previous-sample flop. A level held across at least one rising clock edge is always seen, so a pulse of one clock period or longer sets its flag. A flag-driven request appears after the third rising edge that follows a pin change.
- R6: `ext_req` requires both `gie` and enable bit 0 to be 1. `grp_req[g]` requires both `gie` and enable bit 4+g to be 1. Flags keep their state while these enables are low, so a flag that is already set produces its request once the enables return.
- R7: Group 0 holds pins 7:0, group 1 holds pins 11:8 and group 2 holds pins 17:12. A change on a pin whose per-pin mask bit is 1 sets the flag of its group. A change on a pin whose mask bit is 0 has no effect.
- R8: A flag stays set until its acknowledge is high at a rising edge. If a new event arrives in the same cycle as the acknowledge, the flag stays set.
- R9: The registers are at these addresses. Address 0 is the enable register: bit 0 is the external enable and bits 6:4 are the group 2..0 enables. Bits 7 and 3:1 of this register always read 0. Address 1 holds the sense code in bits 1:0, with the upper bits reading 0. Addresses 2, 3 and 4 hold the masks for groups 0, 1 and 2, which read back exactly as written and are zero-extended to 8 bits. Any other address reads 0.
- R10: After reset, every enable bit, the sense code and all per-pin masks are 0, and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gie | input | 1 | Global interrupt enable |
| ext_pin | input | 1 | Raw dedicated interrupt pin |
| chg_pins | input | 18 | Raw pin-change inputs |
| ext_ack | input | 1 | Clears the external flag |
| grp_ack | input | 3 | Clear the group flags |
| ext_req | output | 1 | External interrupt request |
| grp_req | output | 3 | Pin-change group requests |

## Verification
The assertions assume two things about the inputs. First, pin inputs change away from the rising clock edge, so each synchronizer stage captures a settled value. Second, the pins sit at their idle high level during reset, which matches the reset value of the sample flops. The stimulus obeys both rules. It drives every pin, acknowledge and register write on the falling clock edge, and it holds all pins high until reset has been released. Random pin toggles are spaced far enough apart that each one passes through the full sampling pipeline before the next one is applied.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int unsigned NUM_GRP     = 3;
  localparam int unsigned REG_DW      = 8;
  localparam logic [2:0]  ADDR_ENA    = 3'd0;
  localparam logic [2:0]  ADDR_SNS    = 3'd1;
  localparam logic [2:0]  ADDR_MSK0   = 3'd2;
  localparam int unsigned ENA_EXT_BIT = 0;
  localparam int unsigned ENA_GRP_LSB = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] smp,
  output logic [W-1:0] prv
);
  logic [STAGES-1:0][W-1:0] chain_q, chain_d;
  logic [W-1:0]             prv_q;

  always_comb begin
    chain_d[0] = raw;
    for (int k = 1; k < STAGES; k++) chain_d[k] = chain_q[k-1];
  end

  // Pins idle high; flops reset to match so no false edge follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prv_q   <= '1;
    end else begin
      chain_q <= chain_d;
      prv_q   <= chain_q[STAGES-1];
    end
  end

  assign smp = chain_q[STAGES-1];
  assign prv = prv_q;
endmodule

// File: rtl/ext_sense.sv
module ext_sense
  import irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  logic   prv,
  input  sense_e mode,
  input  logic   ack,
  output logic   flag
);
  logic evt, flag_q, flag_d;

  always_comb begin
    unique case (mode)
      SNS_ANY:  evt = smp ^ prv;
      SNS_FALL: evt = prv & ~smp;
      SNS_RISE: evt = ~prv & smp;
      default:  evt = 1'b0;
    endcase
  end

  always_comb flag_d = evt | (flag_q & ~ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R8
  ext_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  // R8
  ext_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ack && !evt) |=> !flag_q);
  // R3
  ext_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_FALL && $fell(smp)) |=> flag_q);
  // R4
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_RISE && $rose(smp)) |=> flag_q);
endmodule

// File: rtl/chg_group.sv
module chg_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] prv,
  input  logic         ack,
  output logic [W-1:0] mask,
  output logic         flag
);
  logic [W-1:0] mask_q, mask_d;
  logic         flag_q, flag_d, hit;

  always_comb begin
    mask_d = wr_en ? wdata : mask_q;
    hit    = |((smp ^ prv) & mask_q);
    flag_d = hit | (flag_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign mask = mask_q;
  assign flag = flag_q;

  // R7
  grp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp == prv && !flag_q) |=> !flag_q);
  // R8
  grp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ack && !hit) |=> !flag_q);
  // R8
  grp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned G0_W        = 8,
  parameter int unsigned G1_W        = 4,
  parameter int unsigned G2_W        = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [2:0]             reg_addr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic                   gie,
  input  logic                   ext_pin,
  input  logic [G0_W+G1_W+G2_W-1:0] chg_pins,
  input  logic                   ext_ack,
  input  logic [2:0]             grp_ack,
  output logic                   ext_req,
  output logic [2:0]             grp_req
);
  localparam int unsigned PIN_W = G0_W + G1_W + G2_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // Control registers
  logic         ext_en_q, ext_en_d;
  logic [2:0]   grp_en_q, grp_en_d;
  sense_e       sense_q, sense_d;
  logic         wr_ena, wr_sns;

  always_comb begin
    wr_ena   = reg_wr_en && (reg_addr == ADDR_ENA);
    wr_sns   = reg_wr_en && (reg_addr == ADDR_SNS);
    ext_en_d = wr_ena ? reg_wdata[ENA_EXT_BIT] : ext_en_q;
    grp_en_d = wr_ena ? reg_wdata[ENA_GRP_LSB +: NUM_GRP] : grp_en_q;
    sense_d  = wr_sns ? sense_e'(reg_wdata[1:0]) : sense_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_en_q <= 1'b0;
      grp_en_q <= '0;
      sense_q  <= SNS_LOW;
    end else begin
      ext_en_q <= ext_en_d;
      grp_en_q <= grp_en_d;
      sense_q  <= sense_d;
    end
  end

  // Sampling
  logic             ext_smp, ext_prv;
  logic [PIN_W-1:0] chg_smp, chg_prv;

  pin_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_ni), .raw(ext_pin), .smp(ext_smp), .prv(ext_prv));

  pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_chg_sync (
    .clk(clk), .rst_n(rst_ni), .raw(chg_pins), .smp(chg_smp), .prv(chg_prv));

  // Dedicated pin detection
  logic ext_flag;
  ext_sense u_ext (
    .clk(clk), .rst_n(rst_ni), .smp(ext_smp), .prv(ext_prv),
    .mode(sense_q), .ack(ext_ack), .flag(ext_flag));

  // Pin-change groups
  logic [NUM_GRP-1:0]             grp_flag;
  logic [NUM_GRP-1:0][REG_DW-1:0] grp_mask_rd;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned W  = (g == 0) ? G0_W : (g == 1) ? G1_W : G2_W;
    localparam int unsigned LO = (g == 0) ? 0 : (g == 1) ? G0_W : G0_W + G1_W;
    logic [W-1:0]      mask;
    logic [REG_DW-1:0] rd;
    logic              wr;

    assign wr = reg_wr_en && (reg_addr == 3'(ADDR_MSK0 + g));

    chg_group #(.W(W)) u_grp (
      .clk(clk), .rst_n(rst_ni), .wr_en(wr), .wdata(reg_wdata[W-1:0]),
      .smp(chg_smp[LO +: W]), .prv(chg_prv[LO +: W]), .ack(grp_ack[g]),
      .mask(mask), .flag(grp_flag[g]));

    always_comb begin
      rd        = '0;
      rd[W-1:0] = mask;
    end
    assign grp_mask_rd[g] = rd;
  end

  // Requests
  always_comb begin
    ext_req = gie & ext_en_q & ((sense_q == SNS_LOW) ? ~ext_smp : ext_flag);
    grp_req = {NUM_GRP{gie}} & grp_en_q & grp_flag;
  end

  // Read-back
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_ENA: begin
        reg_rdata[ENA_EXT_BIT]              = ext_en_q;
        reg_rdata[ENA_GRP_LSB +: NUM_GRP]   = grp_en_q;
      end
      ADDR_SNS: reg_rdata[1:0] = sense_q;
      3'd2:     reg_rdata = grp_mask_rd[0];
      3'd3:     reg_rdata = grp_mask_rd[1];
      3'd4:     reg_rdata = grp_mask_rd[2];
      default:  reg_rdata = '0;
    endcase
  end

  // R6
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !gie |-> (!ext_req && grp_req == '0));
  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_addr == ADDR_ENA) |-> (!reg_rdata[7] && reg_rdata[3:1] == 3'b000));
  // R1
  level_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sense_q == SNS_LOW && ext_smp) |-> !ext_req);
endmodule

// File: tb/sim_pin_irq_ctrl.sv
module sim_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        gie;
  logic        ext_pin;
  logic [17:0] chg_pins;
  logic        ext_ack;
  logic [2:0]  grp_ack;
  logic        ext_req;
  logic [2:0]  grp_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .ext_pin(ext_pin),
    .chg_pins(chg_pins), .ext_ack(ext_ack), .grp_ack(grp_ack),
    .ext_req(ext_req), .grp_req(grp_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ack_ext();
    ext_ack = 1'b1; cyc(1); ext_ack = 1'b0;
  endtask

  function automatic int grp_of(int p);
    return (p < 8) ? 0 : (p < 12) ? 1 : 2;
  endfunction

  function automatic logic mask_bit(int p, logic [7:0] m0, logic [3:0] m1, logic [5:0] m2);
    if (p < 8)  return m0[p];
    if (p < 12) return m1[p-8];
    return m2[p-12];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    gie = 1'b1; ext_pin = 1'b1; chg_pins = '1; ext_ack = 1'b0; grp_ack = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(5);

    // R10 reset state
    for (int a = 0; a < 5; a++) rd_chk("R10", 3'(a), 8'h00);
    chk("R10 ext_req", ext_req, 0);
    chk("R10 grp_req", grp_req, 0);

    // R9 register map
    wr(3'd0, 8'hFF); rd_chk("R9 enable reserved", 3'd0, 8'h71);
    wr(3'd1, 8'hFF); rd_chk("R9 sense", 3'd1, 8'h03);
    wr(3'd2, 8'hA5); rd_chk("R9 mask0", 3'd2, 8'hA5);
    wr(3'd3, 8'hFF); rd_chk("R9 mask1", 3'd3, 8'h0F);
    wr(3'd4, 8'hFF); rd_chk("R9 mask2", 3'd4, 8'h3F);
    rd_chk("R9 unused", 3'd6, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    ack_ext();

    // R1 low level
    wr(3'd1, 8'h00);
    ext_pin = 1'b0; cyc(3);
    chk("R1 low asserts", ext_req, 1);
    ext_pin = 1'b1; cyc(3);
    chk("R1 no latch", ext_req, 0);

    // R2 any change
    wr(3'd1, 8'h01);
    ext_pin = 1'b0; cyc(4);
    chk("R2 fall change", ext_req, 1);
    ack_ext(); chk("R8 ack clears", ext_req, 0);
    ext_pin = 1'b1; cyc(4);
    chk("R2 rise change", ext_req, 1);
    ack_ext();

    // R3 falling, one-cycle pulse (R5)
    wr(3'd1, 8'h02);
    ext_pin = 1'b0; cyc(1); ext_pin = 1'b1; cyc(4);
    chk("R5 one-cycle pulse / R3", ext_req, 1);
    ack_ext(); chk("R3 rise ignored", ext_req, 0);

    // R4 rising, two-cycle pulse (R5)
    wr(3'd1, 8'h03);
    ext_pin = 1'b0; cyc(2); ext_pin = 1'b1; cyc(4);
    chk("R5 two-cycle pulse / R4", ext_req, 1);
    ack_ext();
    ext_pin = 1'b0; cyc(4);
    chk("R4 fall ignored", ext_req, 0);
    ext_pin = 1'b1; cyc(4);
    chk("R4 rise", ext_req, 1);
    ack_ext(); chk("R8 ack", ext_req, 0);

    // R6 gating
    gie = 1'b0;
    ext_pin = 1'b0; cyc(2); ext_pin = 1'b1; cyc(4);
    chk("R6 gie low blocks", ext_req, 0);
    gie = 1'b1; #1;
    chk("R6 flag kept", ext_req, 1);
    wr(3'd0, 8'h70); chk("R6 ext enable off", ext_req, 0);
    wr(3'd0, 8'h71); chk("R6 ext enable on", ext_req, 1);
    ack_ext();

    // R8 event and ack in the same cycle
    wr(3'd1, 8'h01);
    ext_pin = 1'b0; cyc(4);
    ext_pin = 1'b1; cyc(2);
    ext_ack = 1'b1; cyc(1); ext_ack = 1'b0;
    chk("R8 event wins", ext_req, 1);
    ack_ext(); chk("R8 clear after", ext_req, 0);

    // R7 directed masking
    wr(3'd2, 8'h01); wr(3'd3, 8'h00); wr(3'd4, 8'h20);
    chg_pins[1] = ~chg_pins[1]; cyc(4);
    chk("R7 masked pin1", grp_req, 3'b000);
    chg_pins[8] = ~chg_pins[8]; cyc(4);
    chk("R7 masked pin8", grp_req, 3'b000);
    chg_pins[0] = ~chg_pins[0]; cyc(4);
    chk("R7 pin0", grp_req, 3'b001);
    chg_pins[17] = ~chg_pins[17]; cyc(4);
    chk("R7 pin17", grp_req, 3'b101);
    wr(3'd0, 8'h61);
    chk("R6 group enable off", grp_req, 3'b100);
    wr(3'd0, 8'h71);
    grp_ack = 3'b111; cyc(1); grp_ack = '0;
    chk("R8 group ack", grp_req, 3'b000);

    // R7 random
    for (int it = 0; it < 60; it++) begin
      logic [7:0] m0, m1, m2;
      logic       g;
      int         p;
      logic [2:0] e;
      m0 = 8'($urandom); m1 = 8'($urandom); m2 = 8'($urandom);
      wr(3'd2, m0); wr(3'd3, m1); wr(3'd4, m2);
      g = 1'($urandom);
      gie = g;
      p = int'($urandom % 18);
      chg_pins[p] = ~chg_pins[p];
      cyc(4);
      e = '0;
      e[grp_of(p)] = g & mask_bit(p, m0, m1[3:0], m2[5:0]);
      chk("R7 random", grp_req, e);
      gie = 1'b1;
      grp_ack = 3'b111; cyc(1); grp_ack = '0;
      chk("R8 random ack", grp_req, 3'b000);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule